// File: doc/BRIEF.md
# Audio Sample Input Formatter

This block is the host-facing front end of a two-channel digital audio transmitter. A CPU or DMA engine writes 32-bit words to one shared data register. The block routes each word to one or both per-channel sample queues. The routing depends on the channel count and the selected access scheme. Before a word is queued, it is reshaped: trimmed to the programmed byte count, optionally byte-swapped, masked to the valid-bit count and aligned to the low or high end.

The downstream subframe encoder asks for one sample at a time, naming the subframe it is about to build. The block answers one cycle later on `smp_data`. In single-channel operation, one queued sample feeds both subframes.

Several registers sit behind a simple read/write port:

- a control register of self-clearing commands;
- a mode register;
- a status register with level bits and sticky event bits;
- a pair of set/clear ports for the interrupt mask, plus a mask readback.

The interrupt line is raised while any masked status bit is set. A burst request (`dma_req`) tells a DMA engine that each active queue has room for a whole chunk.

Routing is driven by a small state machine with two states. `DS_CH1` means the next toggle-mode write belongs to channel 1, and `DS_CH2` means it belongs to channel 2. It has three transitions:

- A data write in dual-channel toggle mode moves `DS_CH1`→`DS_CH2`.
- The next such write moves `DS_CH2`→`DS_CH1`.
- A soft reset or a queue clear forces `DS_CH1` from either state.

Top module: `audio_sample_formatter`

Register offsets: control 0x00, mode 0x04, data 0x08, mask-set 0x10, mask-clear 0x14, mask readback 0x18, status 0x1C.

## Requirements
- R1: Writing the control register with bit 0 set is a soft reset. It clears the mode register, the interrupt mask, both queues, all sticky flags and the toggle position (to `DS_CH1`). Afterwards the mode readback is 0 and the status readback is 0x30B.
- R2: Writing the control register with bit 1 set empties both queues and returns toggle routing to `DS_CH1`. The mode register and the interrupt mask are left unchanged.
- R3: The mode register holds these fields:
  - bit 0: transmit enable;
  - bit 1: dual-channel (1) or single-channel (0);
  - bit 2: big-endian (1);
  - bit 3: MSB justification (1);
  - bits 5:4: access scheme (0 indexed, 1 toggle, 2 interleaved);
  - bit 6: indexed target (0 channel 1, 1 channel 2);
  - bits 13:8: valid bits;
  - bits 19:16: chunk;
  - bits 29:28: bytes per sample minus one.

  All other bits read back 0, so writing all ones reads back 0x300F3F7F.
- R4: Each written word is shaped before it is queued, in this order:
  - It is trimmed to the programmed number of bytes.
  - In big-endian mode, the bytes within that span are reversed.
  - It is masked to the programmed number of valid bits. A field value of 0 or above 32 means 32.
  - With MSB justification, it is shifted left so that the top valid bit lands on bit 31. Otherwise it stays right-aligned.
- R5: In dual-channel toggle mode, successive data writes go alternately to channel 1 and channel 2, starting with channel 1.
- R6: In dual-channel indexed mode, every data write goes to the channel named by mode bit 6.
- R7: In dual-channel interleaved mode, one data write queues its low 16 bits to channel 1 and its high 16 bits to channel 2. Each half is shaped separately.
- R8: In single-channel mode, every write goes to the channel 1 queue. A request for subframe 1 (`smp_ch`=0) dequeues a sample. A request for subframe 2 (`smp_ch`=1) returns that same sample again without dequeuing.
- R9: Each queue holds 4 samples. A write aimed at a full queue is dropped and sets the sticky overrun flag (status bit 5).
- R10: A request to an empty queue while transmitting returns 0 on `smp_data`. It sets sticky underrun (bit 4) and the per-channel underrun flag (bit 11 for channel 1, bit 12 for channel 2).
- R11: Status level bits, each evaluated over the active channels:
  - bit 0: ready, meaning no active queue is full;
  - bit 1: all active queues are empty;
  - bit 2: some active queue is full;
  - bit 3: chunk, meaning every active queue has at least max(chunk,1) free places;
  - bits 8 and 9: per-channel not-full.

  `dma_req` equals bit 3 while transmit is enabled.
- R12: Reading the status register returns the flags as they were and then clears bits 4, 5, 11 and 12. An event in the same cycle as the read stays set.
- R13: A write to the mask-set port ORs its bits into the mask, and a write to the mask-clear port clears them. The mask readback returns the mask. `irq` is high exactly when status AND mask is nonzero.
- R14: While transmit is disabled, a request returns 0 on `smp_data`, dequeues nothing and raises no underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data valid after the next edge |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| smp_req | input | 1 | Encoder sample request |
| smp_ch | input | 1 | Requested subframe (0 first, 1 second) |
| smp_data | output | 32 | Aligned sample, valid the cycle after the request |
| dma_req | output | 1 | Burst request: room for a chunk in every active queue |
| irq | output | 1 | Interrupt, masked status nonzero |

## Verification
Several properties are checked on every cycle:

- the queue occupancy bound, and that a push to a full queue leaves the occupancy unchanged;
- that outside interleaved mode a write targets at most one queue;
- that a soft reset clears the mode and the mask;
- that a dual-channel request on an empty queue yields zero and flags underrun;
- that the queue levels stay still while transmit is off;
- that `irq` never rises with an empty mask.

Some behaviours can only be shown by the directed scenarios, because they depend on the sequence of data rather than on any single cycle:

- byte trimming, swapping and justification values;
- the toggle alternation order and its restart after a clear;
- interleaved half splitting;
- the single-channel repeat of a sample to the second subframe;
- the exact status words and the clearing of sticky flags on read.

// File: rtl/asf_pkg.sv
package asf_pkg;
    localparam int WORD_W  = 32;
    localparam int NCH     = 2;
    localparam int STAT_W  = 14;

    localparam int A_CTRL  = 'h00;
    localparam int A_MODE  = 'h04;
    localparam int A_DATA  = 'h08;
    localparam int A_MSET  = 'h10;
    localparam int A_MCLR  = 'h14;
    localparam int A_MASK  = 'h18;
    localparam int A_STAT  = 'h1C;

    localparam int SB_READY = 0;
    localparam int SB_EMPTY = 1;
    localparam int SB_FULL  = 2;
    localparam int SB_CHUNK = 3;
    localparam int SB_UDR   = 4;
    localparam int SB_OVR   = 5;
    localparam int SB_RDY1  = 8;
    localparam int SB_UDR1  = 11;

    localparam logic [WORD_W-1:0] MODE_WMASK = 32'h300F_3F7F;

    typedef enum logic [1:0] {
        ACC_INDEX      = 2'd0,
        ACC_TOGGLE     = 2'd1,
        ACC_INTERLEAVE = 2'd2
    } acc_mode_e;

    typedef enum logic {
        DS_CH1 = 1'b0,
        DS_CH2 = 1'b1
    } dist_state_e;

    typedef struct packed {
        logic [1:0] pad_hi;
        logic [1:0] bytes_m1;
        logic [7:0] pad_b;
        logic [3:0] chunk;
        logic [1:0] pad_c;
        logic [5:0] vbits;
        logic       pad_d;
        logic       idx_ch;
        acc_mode_e  acc;
        logic       msb_just;
        logic       big_end;
        logic       dual;
        logic       tx_en;
    } mode_t;
endpackage

// File: rtl/asf_fifo.sv
module asf_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign rdata   = mem[rp];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else if (clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            if (do_push && !do_pop)      count <= count + CW'(1);
            else if (!do_push && do_pop) count <= count - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));  // R9
    AST_FULL_PUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (count == $past(count)));  // R9
endmodule

// File: rtl/asf_fmt.sv
module asf_fmt #(
    parameter int W    = 32,
    localparam int NB  = W / 8,
    localparam int BMW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic [W-1:0]   raw,
    input  logic [BMW-1:0] bytes_m1,
    input  logic [5:0]     vbits,
    input  logic           big,
    input  logic           msb,
    output logic [W-1:0]   shaped
);
    logic [W-1:0] sw, lowmask, val;
    int           vbe;
    int           top;

    always_comb begin
        top = int'(bytes_m1);
        sw  = '0;
        for (int i = 0; i < NB; i++) begin
            if (i <= top) begin
                sw[i*8 +: 8] = big ? raw[(top - i)*8 +: 8] : raw[i*8 +: 8];
            end
        end
        vbe     = (vbits == '0 || int'(vbits) > W) ? W : int'(vbits);
        lowmask = (vbe >= W) ? '1 : ((W'(1) << vbe) - W'(1));
        val     = sw & lowmask;
        shaped  = msb ? (val << (W - vbe)) : val;
    end
endmodule

// File: rtl/asf_dist.sv
module asf_dist
    import asf_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           wr,
    input  logic           dual,
    input  acc_mode_e      acc,
    input  logic           idx_ch,
    output logic [NCH-1:0] push,
    output logic           split
);
    dist_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DS_CH1;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = DS_CH1;
        end else if (wr && dual && acc == ACC_TOGGLE) begin
            unique case (state_q)
                DS_CH1: state_d = DS_CH2;
                DS_CH2: state_d = DS_CH1;
            endcase
        end
    end

    always_comb begin
        push  = '0;
        split = dual && (acc == ACC_INTERLEAVE);
        if (wr && !clr) begin
            if (!dual) begin
                push = 2'b01;
            end else begin
                unique case (acc)
                    ACC_TOGGLE:     push = (state_q == DS_CH1) ? 2'b01 : 2'b10;
                    ACC_INTERLEAVE: push = 2'b11;
                    default:        push = idx_ch ? 2'b10 : 2'b01;
                endcase
            end
        end
    end

    AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (!split) |-> ($countones(push) <= 1));  // R5
endmodule

// File: rtl/audio_sample_formatter.sv
module audio_sample_formatter
    import asf_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int ADDR_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              smp_req,
    input  logic              smp_ch,
    output logic [31:0]       smp_data,
    output logic              dma_req,
    output logic              irq
);
    localparam int CW   = $clog2(FIFO_DEPTH + 1);
    localparam int HALF = WORD_W / 2;

    mode_t              mode_q;
    logic [STAT_W-1:0]  mask_q;
    logic [STAT_W-1:0]  stat;
    logic               ovr_q, udr_q;
    logic [NCH-1:0]     udr_ch_q;
    logic [WORD_W-1:0]  hold_q;

    logic               soft_rst, q_clr, fifo_clr, data_wr, stat_rd;
    logic [NCH-1:0]     push, pop, full, empty, ch_ok, udr_ev;
    logic               split, ovr_ev, lane, take;
    logic [WORD_W-1:0]  lane_raw [NCH];
    logic [WORD_W-1:0]  lane_fmt [NCH];
    logic [WORD_W-1:0]  fdata    [NCH];
    logic [CW-1:0]      cnt      [NCH];
    int                 need;

    assign soft_rst = reg_wr && reg_addr == ADDR_W'(A_CTRL) && reg_wdata[0];
    assign q_clr    = reg_wr && reg_addr == ADDR_W'(A_CTRL) && reg_wdata[1];
    assign fifo_clr = soft_rst || q_clr;
    assign data_wr  = reg_wr && reg_addr == ADDR_W'(A_DATA);
    assign stat_rd  = reg_rd && reg_addr == ADDR_W'(A_STAT);

    asf_dist u_dist (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (fifo_clr),
        .wr     (data_wr),
        .dual   (mode_q.dual),
        .acc    (mode_q.acc),
        .idx_ch (mode_q.idx_ch),
        .push   (push),
        .split  (split)
    );

    assign lane_raw[0] = split ? {{HALF{1'b0}}, reg_wdata[HALF-1:0]} : reg_wdata;
    assign lane_raw[1] = split ? {{HALF{1'b0}}, reg_wdata[WORD_W-1:HALF]} : reg_wdata;

    assign take   = smp_req && mode_q.tx_en;
    assign pop[0] = take && !smp_ch;
    assign pop[1] = take && mode_q.dual && smp_ch;
    assign lane   = mode_q.dual && smp_ch;

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        asf_fmt #(.W(WORD_W)) u_fmt (
            .raw      (lane_raw[c]),
            .bytes_m1 (mode_q.bytes_m1),
            .vbits    (mode_q.vbits),
            .big      (mode_q.big_end),
            .msb      (mode_q.msb_just),
            .shaped   (lane_fmt[c])
        );
        asf_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (fifo_clr),
            .push  (push[c]),
            .wdata (lane_fmt[c]),
            .pop   (pop[c]),
            .rdata (fdata[c]),
            .count (cnt[c]),
            .full  (full[c]),
            .empty (empty[c])
        );
        assign ch_ok[c]  = (FIFO_DEPTH - int'(cnt[c])) >= need;
        assign udr_ev[c] = pop[c] && empty[c];
    end

    assign need   = (mode_q.chunk == '0) ? 1 : int'(mode_q.chunk);
    assign ovr_ev = |(push & full);

    always_comb begin
        stat           = '0;
        stat[SB_READY] = !full[0] && (!mode_q.dual || !full[1]);
        stat[SB_EMPTY] = empty[0] && (!mode_q.dual || empty[1]);
        stat[SB_FULL]  = full[0] || (mode_q.dual && full[1]);
        stat[SB_CHUNK] = ch_ok[0] && (!mode_q.dual || ch_ok[1]);
        stat[SB_UDR]   = udr_q;
        stat[SB_OVR]   = ovr_q;
        stat[SB_RDY1 +: NCH] = ~full;
        stat[SB_UDR1 +: NCH] = udr_ch_q;
    end

    assign irq     = |(stat & mask_q);
    assign dma_req = mode_q.tx_en && stat[SB_CHUNK];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            mask_q   <= '0;
            ovr_q    <= 1'b0;
            udr_q    <= 1'b0;
            udr_ch_q <= '0;
        end else if (soft_rst) begin
            mode_q   <= '0;
            mask_q   <= '0;
            ovr_q    <= 1'b0;
            udr_q    <= 1'b0;
            udr_ch_q <= '0;
        end else begin
            if (reg_wr && reg_addr == ADDR_W'(A_MODE))
                mode_q <= mode_t'(reg_wdata & MODE_WMASK);
            if (reg_wr && reg_addr == ADDR_W'(A_MSET))
                mask_q <= mask_q | reg_wdata[STAT_W-1:0];
            if (reg_wr && reg_addr == ADDR_W'(A_MCLR))
                mask_q <= mask_q & ~reg_wdata[STAT_W-1:0];
            ovr_q    <= (ovr_q && !stat_rd) || ovr_ev;
            udr_q    <= (udr_q && !stat_rd) || (|udr_ev);
            udr_ch_q <= (stat_rd ? '0 : udr_ch_q) | udr_ev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            if (reg_addr == ADDR_W'(A_MODE))      reg_rdata <= mode_q;
            else if (reg_addr == ADDR_W'(A_MASK)) reg_rdata <= {{(32-STAT_W){1'b0}}, mask_q};
            else if (reg_addr == ADDR_W'(A_STAT)) reg_rdata <= {{(32-STAT_W){1'b0}}, stat};
            else                                  reg_rdata <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_data <= '0;
            hold_q   <= '0;
        end else if (soft_rst) begin
            smp_data <= '0;
            hold_q   <= '0;
        end else if (smp_req) begin
            if (!mode_q.tx_en) begin
                smp_data <= '0;
            end else if (!mode_q.dual && smp_ch) begin
                smp_data <= hold_q;
            end else begin
                smp_data <= empty[lane] ? '0 : fdata[lane];
                if (!mode_q.dual) hold_q <= empty[0] ? '0 : fdata[0];
            end
        end
    end

    AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (mode_q == '0 && mask_q == '0));  // R1
    AST_UNDERRUN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_req && mode_q.tx_en && mode_q.dual && empty[smp_ch] && !soft_rst)
            |=> (smp_data == '0 && udr_q));  // R10
    AST_TX_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q.tx_en && !reg_wr) |=> (cnt[0] == $past(cnt[0]) && cnt[1] == $past(cnt[1])));  // R14
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q != '0));  // R13
endmodule

// File: tb/tb_audio_sample_formatter.sv
module tb_audio_sample_formatter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        smp_req = 1'b0, smp_ch = 1'b0;
    logic [31:0] smp_data;
    logic        dma_req, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [7:0] CTRL = 8'h00, MODE = 8'h04, DATA = 8'h08,
                           MSET = 8'h10, MCLR = 8'h14, MASK = 8'h18, STAT = 8'h1C;

    always #4 clk = ~clk;

    audio_sample_formatter dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .smp_req(smp_req), .smp_ch(smp_ch), .smp_data(smp_data),
        .dma_req(dma_req), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic req(input logic ch, output logic [31:0] d);
        @(negedge clk);
        smp_req = 1'b1; smp_ch = ch;
        @(negedge clk);
        smp_req = 1'b0;
        d = smp_data;
    endtask

    function automatic logic [31:0] mw(input bit en, input bit dual, input bit big, input bit msb,
                                       input int acc, input bit idx, input int vb,
                                       input int chunk, input int bm1);
        return 32'(en) | (32'(dual) << 1) | (32'(big) << 2) | (32'(msb) << 3) |
               (32'(acc) << 4) | (32'(idx) << 6) | (32'(vb) << 8) |
               (32'(chunk) << 16) | (32'(bm1) << 28);
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        rd(MODE, v);  check("R1 mode after reset", v, 32'h0);
        rd(STAT, v);  check("R11 status after reset", v, 32'h30B);
        check("R14 dma_req off while disabled", {31'b0, dma_req}, 32'h0);
        wr(MODE, 32'hFFFF_FFFF);
        rd(MODE, v);  check("R3 mode readback mask", v, 32'h300F_3F7F);
        wr(MODE, 32'h0);
    endtask

    task automatic t_format();
        logic [31:0] v;
        wr(MODE, mw(1, 0, 0, 0, 0, 0, 24, 0, 2));
        wr(DATA, 32'hFFAB_CDEF); req(0, v); check("R4 3-byte lsb", v, 32'h00AB_CDEF);
        wr(MODE, mw(1, 0, 0, 1, 0, 0, 24, 0, 2));
        wr(DATA, 32'h1122_3344); req(0, v); check("R4 3-byte msb", v, 32'h2233_4400);
        wr(MODE, mw(1, 0, 1, 0, 0, 0, 24, 0, 2));
        wr(DATA, 32'h0012_3456); req(0, v); check("R4 3-byte big", v, 32'h0056_3412);
        wr(MODE, mw(1, 0, 1, 1, 0, 0, 16, 0, 1));
        wr(DATA, 32'h0000_A1B2); req(0, v); check("R4 2-byte big msb", v, 32'hB2A1_0000);
        wr(MODE, mw(1, 0, 0, 0, 0, 0, 18, 0, 2));
        wr(DATA, 32'h00FF_FFFF); req(0, v); check("R4 18 valid bits", v, 32'h0003_FFFF);
        wr(MODE, mw(1, 0, 1, 0, 0, 0, 32, 0, 3));
        wr(DATA, 32'h0102_0304); req(0, v); check("R4 4-byte big", v, 32'h0403_0201);
    endtask

    task automatic t_toggle();
        logic [31:0] v;
        wr(MODE, mw(1, 1, 0, 0, 1, 0, 32, 0, 3));
        wr(CTRL, 32'h2);
        wr(DATA, 32'h1111_0001); wr(DATA, 32'h2222_0001);
        wr(DATA, 32'h1111_0002); wr(DATA, 32'h2222_0002);
        req(1, v); check("R5 toggle ch2 first", v, 32'h2222_0001);
        req(0, v); check("R5 toggle ch1 first", v, 32'h1111_0001);
        req(0, v); check("R5 toggle ch1 second", v, 32'h1111_0002);
        req(1, v); check("R5 toggle ch2 second", v, 32'h2222_0002);
    endtask

    task automatic t_index();
        logic [31:0] v;
        wr(MODE, mw(1, 1, 0, 0, 0, 1, 32, 0, 3));
        wr(DATA, 32'hC0DE_0001);
        wr(MODE, mw(1, 1, 0, 0, 0, 0, 32, 0, 3));
        wr(DATA, 32'hC0DE_0002);
        req(0, v); check("R6 indexed ch1", v, 32'hC0DE_0002);
        req(1, v); check("R6 indexed ch2", v, 32'hC0DE_0001);
    endtask

    task automatic t_interleave();
        logic [31:0] v;
        wr(MODE, mw(1, 1, 0, 0, 2, 0, 16, 0, 1));
        wr(DATA, 32'hBEEF_1234);
        req(0, v); check("R7 interleave low half", v, 32'h0000_1234);
        req(1, v); check("R7 interleave high half", v, 32'h0000_BEEF);
    endtask

    task automatic t_mono();
        logic [31:0] v;
        wr(MODE, mw(1, 0, 0, 0, 1, 0, 32, 0, 3));
        wr(CTRL, 32'h2);
        wr(DATA, 32'h5A5A_0001); wr(DATA, 32'h5A5A_0002);
        req(0, v); check("R8 mono sub1", v, 32'h5A5A_0001);
        req(1, v); check("R8 mono sub2 repeats", v, 32'h5A5A_0001);
        req(1, v); check("R8 mono sub2 no pop", v, 32'h5A5A_0001);
        req(0, v); check("R8 mono next sample", v, 32'h5A5A_0002);
    endtask

    task automatic t_overrun_underrun();
        logic [31:0] v;
        wr(MODE, mw(0, 0, 0, 0, 0, 0, 32, 0, 3));
        wr(CTRL, 32'h2);
        rd(STAT, v);
        for (int i = 0; i < 4; i++) wr(DATA, 32'hD000_0000 + 32'(i));
        rd(STAT, v); check("R11 full status", v, 32'h204);
        req(0, v);   check("R14 disabled request zero", v, 32'h0);
        rd(STAT, v); check("R14 disabled no pop", v, 32'h204);
        wr(DATA, 32'hD000_0004);
        rd(STAT, v); check("R9 overrun flag", v, 32'h224);
        rd(STAT, v); check("R12 overrun cleared by read", v, 32'h204);
        wr(MODE, mw(1, 0, 0, 0, 0, 0, 32, 0, 3));
        for (int i = 0; i < 4; i++) begin
            req(0, v); check("R9 kept samples", v, 32'hD000_0000 + 32'(i));
        end
        req(0, v);   check("R10 underrun zero", v, 32'h0);
        rd(STAT, v); check("R10 underrun flags", v, 32'hB1B);
        rd(STAT, v); check("R12 underrun cleared", v, 32'h30B);
    endtask

    task automatic t_chunk();
        logic [31:0] v;
        wr(MODE, mw(1, 1, 0, 0, 1, 0, 32, 2, 3));
        wr(CTRL, 32'h2);
        check("R11 dma_req empty", {31'b0, dma_req}, 32'h1);
        for (int i = 0; i < 4; i++) wr(DATA, 32'h7700_0000 + 32'(i));
        check("R11 dma_req two free", {31'b0, dma_req}, 32'h1);
        wr(DATA, 32'h7700_0004);
        check("R11 dma_req one free", {31'b0, dma_req}, 32'h0);
        rd(STAT, v); check("R11 chunk bit low", v, 32'h301);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(CTRL, 32'h1);
        wr(MSET, 32'h30);
        rd(MASK, v); check("R13 mask set", v, 32'h30);
        check("R13 irq idle", {31'b0, irq}, 32'h0);
        for (int i = 0; i < 5; i++) wr(DATA, 32'(i));
        check("R13 irq on overrun", {31'b0, irq}, 32'h1);
        wr(MCLR, 32'h20);
        rd(MASK, v); check("R13 mask clear", v, 32'h10);
        check("R13 irq masked off", {31'b0, irq}, 32'h0);
        wr(MSET, 32'h04);
        check("R13 irq on full", {31'b0, irq}, 32'h1);
        wr(CTRL, 32'h1);
        rd(MODE, v); check("R1 soft reset mode", v, 32'h0);
        rd(MASK, v); check("R1 soft reset mask", v, 32'h0);
        rd(STAT, v); check("R1 soft reset status", v, 32'h30B);
        check("R1 irq after soft reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_fifo_clear();
        logic [31:0] v;
        wr(MODE, mw(1, 1, 0, 0, 1, 0, 32, 0, 3));
        wr(DATA, 32'hAAAA_0001);
        wr(MSET, 32'h01);
        wr(CTRL, 32'h2);
        rd(MODE, v); check("R2 mode kept", v, mw(1, 1, 0, 0, 1, 0, 32, 0, 3));
        rd(MASK, v); check("R2 mask kept", v, 32'h01);
        rd(STAT, v); check("R2 queues empty", v, 32'h30B);
        wr(DATA, 32'hAAAA_0002);
        req(0, v); check("R2 toggle restarts at ch1", v, 32'hAAAA_0002);
        req(1, v); check("R2 ch2 still empty", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_format();
        t_toggle();
        t_index();
        t_interleave();
        t_mono();
        t_overrun_underrun();
        t_chunk();
        t_irq();
        t_fifo_clear();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule